// File: doc/BRIEF.md
# Complex Gold-Code Scrambling Chip Generator

This block produces a complex downlink scrambling code one chip per advance. Two 18-stage linear feedback shift registers run side by side. The first implements the feedback polynomial 1 + X^7 + X^18 and the second implements 1 + X^5 + X^7 + X^10 + X^18. The in-phase chip is the XOR of the two register outputs, which gives one member of a Gold family. The quadrature chip is the XOR of two parity sums taken over fixed sets of register taps. These sums reproduce the same Gold sequence 131072 chips later.

A code is selected by a code number. The first register starts from a state that is advanced 16 steps for each unit of the code number, which spaces the selectable codes 16 chips apart. The sequence is cut to one 10 ms frame of 38400 chips. After the last chip the generator reloads by itself and restarts the same code.

A consumer pulses `frame_start` to align a frame and choose a code. It raises `chip_adv` once per chip it consumes and reads `chip_i` and `chip_q` as signed antipodal values.

Top module: `scram_code_gen`

## Requirements
- R1: After reset the outputs present chip 0 of code number 0, and `last_chip` is low.
- R2: Chip k of code number n on `chip_i` is x(k + 16n) XOR y(k). The sequence x starts from a state with only its oldest stage set and follows 1 + X^7 + X^18. The sequence y starts from all ones and follows 1 + X^5 + X^7 + X^10 + X^18. A chip bit of 0 is driven as +1 (2'b01) and a bit of 1 as -1 (2'b11).
- R3: Chip k on `chip_q` equals the in-phase Gold bit at index k + 131072, using the same code number and the same mapping as R2.
- R4: When `frame_start` is high at a clock edge, the generator loads the code number present at that edge, and chip 0 of that code appears after the edge. `frame_start` wins over `chip_adv` in the same cycle.
- R5: A clock edge with `chip_adv` and `frame_start` both low leaves `chip_i`, `chip_q` and `last_chip` unchanged.
- R6: `last_chip` is high exactly while chip 38399 of the frame is presented.
- R7: An advance from chip 38399 presents chip 0 of the code number latched at the last frame start. A change of `code_num` outside a frame start has no effect.
- R8: Any code number from 0 to 511 is accepted. Each step of the code number shifts the first sequence by 16 chips.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| code_num | input | 9 | Code number, sampled on frame start |
| frame_start | input | 1 | Reload both registers and restart at chip 0 |
| chip_adv | input | 1 | Advance to the next chip |
| chip_i | output | 2 | In-phase chip, signed: 01 = +1, 11 = -1 |
| chip_q | output | 2 | Quadrature chip, signed: 01 = +1, 11 = -1 |
| last_chip | output | 1 | High while the final chip of the frame is presented |

## Verification
Each of the three outputs is decoded straight from the registers, so any change caused by a `frame_start` or `chip_adv` at a clock edge appears right after that edge and stays until the next one. The driver applies the inputs at the falling edge. At the same moment it advances a bench model of the two m-sequences and queues the chip pair and flag that must follow the coming rising edge. The monitor takes one item from the queue 1 ns after each rising edge and compares it, so every check looks exactly one register stage behind its stimulus. Full frames are run for two code numbers, which checks the wrap and the flag at chip 38399.

// File: rtl/scram_code_gen.sv
module scram_code_gen #(
  parameter int CODE_W      = 9,
  parameter int SPACING_LOG = 4,
  parameter int FRAME_LEN   = 38400,
  parameter int Q_DELAY_LOG = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code_num,
  input  logic              frame_start,
  input  logic              chip_adv,
  output logic [1:0]        chip_i,
  output logic [1:0]        chip_q,
  output logic              last_chip
);

  localparam int REG_W = 18;
  localparam int CNT_W = $clog2(FRAME_LEN);
  localparam logic [REG_W-1:0] X_FB = 18'h00081;
  localparam logic [REG_W-1:0] Y_FB = 18'h004A1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_LEN - 1);

  typedef logic [REG_W-1:0][REG_W-1:0] mat_t;

  function automatic mat_t step_mat(input logic [REG_W-1:0] fb);
    mat_t m;
    for (int k = 0; k < REG_W - 1; k++) m[k] = REG_W'(1) << (k + 1);
    m[REG_W-1] = fb;
    return m;
  endfunction

  function automatic mat_t mat_sq(input mat_t a);
    mat_t b;
    for (int r = 0; r < REG_W; r++) begin
      logic [REG_W-1:0] acc;
      acc = '0;
      for (int c = 0; c < REG_W; c++) if (a[r][c]) acc = acc ^ a[c];
      b[r] = acc;
    end
    return b;
  endfunction

  function automatic mat_t jump_mat(input logic [REG_W-1:0] fb, input int p);
    mat_t m;
    m = step_mat(fb);
    for (int i = 0; i < p; i++) m = mat_sq(m);
    return m;
  endfunction

  function automatic logic [REG_W-1:0] mat_apply(input mat_t m, input logic [REG_W-1:0] v);
    logic [REG_W-1:0] o;
    for (int r = 0; r < REG_W; r++) o[r] = ^(m[r] & v);
    return o;
  endfunction

  localparam mat_t XQ_M = jump_mat(X_FB, Q_DELAY_LOG);
  localparam mat_t YQ_M = jump_mat(Y_FB, Q_DELAY_LOG);
  localparam logic [REG_W-1:0] XQ_TAP = XQ_M[0];
  localparam logic [REG_W-1:0] YQ_TAP = YQ_M[0];

  logic [REG_W-1:0]  x_q, y_q;
  logic [CNT_W-1:0]  cnt;
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] sel_code;
  logic [REG_W-1:0]  seed_stage [CODE_W+1];
  logic [REG_W-1:0]  x_next, y_next;
  logic              bit_i, bit_q;

  assign sel_code      = frame_start ? code_num : code_q;
  assign seed_stage[0] = REG_W'(1);

  for (genvar g = 0; g < CODE_W; g++) begin : g_seed
    localparam mat_t JM = jump_mat(X_FB, SPACING_LOG + g);
    assign seed_stage[g+1] = sel_code[g] ? mat_apply(JM, seed_stage[g]) : seed_stage[g];
  end

  assign x_next = {^(x_q & X_FB), x_q[REG_W-1:1]};
  assign y_next = {^(y_q & Y_FB), y_q[REG_W-1:1]};

  assign last_chip = (cnt == LAST_IDX);
  assign bit_i     = x_q[0] ^ y_q[0];
  assign bit_q     = ^(x_q & XQ_TAP) ^ ^(y_q & YQ_TAP);
  assign chip_i    = bit_i ? 2'b11 : 2'b01;
  assign chip_q    = bit_q ? 2'b11 : 2'b01;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q    <= REG_W'(1);
      y_q    <= '1;
      cnt    <= '0;
      code_q <= '0;
    end else if (frame_start) begin
      x_q    <= seed_stage[CODE_W];
      y_q    <= '1;
      cnt    <= '0;
      code_q <= code_num;
    end else if (chip_adv) begin
      if (last_chip) begin
        x_q <= seed_stage[CODE_W];
        y_q <= '1;
        cnt <= '0;
      end else begin
        x_q <= x_next;
        y_q <= y_next;
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!chip_adv && !frame_start) |=> ($stable(x_q) && $stable(y_q) && $stable(cnt))); // R5

  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cnt == '0 && y_q == '1 && code_q == $past(code_num))); // R4

  AST_WRAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_adv && !frame_start && last_chip) |=> (cnt == '0 && y_q == '1 && $stable(code_q))); // R7

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_adv && !frame_start && !last_chip) |=> (cnt == $past(cnt) + 1'b1)); // R6

  AST_X_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (x_q != '0)); // R2

endmodule

// File: tb/scram_code_gen_bench.sv
module scram_code_gen_bench;
  localparam int FRAME_LEN = 38400;
  localparam int QDLY      = 131072;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] code_num = '0;
  logic       frame_start = 1'b0;
  logic       chip_adv = 1'b0;
  logic [1:0] chip_i, chip_q;
  logic       last_chip;

  scram_code_gen u_scram_code_gen (
    .clk(clk), .rst_n(rst_n), .code_num(code_num), .frame_start(frame_start),
    .chip_adv(chip_adv), .chip_i(chip_i), .chip_q(chip_q), .last_chip(last_chip)
  );

  always #2 clk = ~clk;

  typedef struct { logic [1:0] ei; logic [1:0] eq; logic el; string tag; } item_t;
  item_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;

  logic [17:0] xa, ya, xb, yb, x_base, y_base;
  int          ci;
  int          cur_code;

  function automatic logic [17:0] xstep(input logic [17:0] s);
    return {s[0] ^ s[7], s[17:1]};
  endfunction
  function automatic logic [17:0] ystep(input logic [17:0] s);
    return {s[0] ^ s[5] ^ s[7] ^ s[10], s[17:1]};
  endfunction
  function automatic logic [1:0] amap(input logic b);
    return b ? 2'b11 : 2'b01;
  endfunction

  task automatic reseed(input int c);
    cur_code = c;
    xa = 18'h1;
    xb = x_base;
    for (int k = 0; k < 16 * c; k++) begin
      xa = xstep(xa);
      xb = xstep(xb);
    end
    ya = '1;
    yb = y_base;
    ci = 0;
  endtask

  task automatic check(input string tag, input logic [2:0] act, input logic [2:0] expv);
    n_checks++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, expv);
    end
  endtask

  task automatic compare(input item_t it);
    string tq;
    tq = (cur_code != 0) ? "R8" : "R2";
    check({it.tag, "/", tq, " chip_i"}, {1'b0, chip_i}, {1'b0, it.ei});
    check({it.tag, "/R3 chip_q"}, {1'b0, chip_q}, {1'b0, it.eq});
    check({it.tag, "/R6 last_chip"}, {2'b0, last_chip}, {2'b0, it.el});
  endtask

  task automatic drive(input logic fs, input logic adv, input int c, input string tag);
    item_t it;
    @(negedge clk);
    frame_start = fs;
    chip_adv    = adv;
    code_num    = 9'(c);
    if (fs) reseed(c);
    else if (adv) begin
      if (ci == FRAME_LEN - 1) reseed(cur_code);
      else begin
        xa = xstep(xa); ya = ystep(ya); xb = xstep(xb); yb = ystep(yb);
        ci++;
      end
    end
    it.ei  = amap(xa[0] ^ ya[0]);
    it.eq  = amap(xb[0] ^ yb[0]);
    it.el  = (ci == FRAME_LEN - 1);
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    item_t it0;
    x_base = 18'h1;
    y_base = '1;
    for (int k = 0; k < QDLY; k++) begin
      x_base = xstep(x_base);
      y_base = ystep(y_base);
    end
    reseed(0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #0;
    // R1: reset state is chip 0 of code 0
    it0.ei = amap(xa[0] ^ ya[0]); it0.eq = amap(xb[0] ^ yb[0]); it0.el = 1'b0; it0.tag = "R1";
    compare(it0);

    // full frame of code 0 and wrap (R6, R7)
    for (int k = 0; k < FRAME_LEN + 4; k++)
      drive(1'b0, 1'b1, 0, (k >= FRAME_LEN - 2) ? "R7" : "R2");

    // R4: start with code 511, then gapped advancing (R5) and ignored code changes (R7)
    drive(1'b1, 1'b0, 511, "R4");
    for (int k = 0; k < 300; k++)
      drive(1'b0, (k % 3) != 2, (k > 100) ? 77 : 511, ((k % 3) == 2) ? "R5" : "R7");

    // R4: start with advance in the same cycle, code 1, full frame plus wrap
    drive(1'b1, 1'b1, 1, "R4");
    for (int k = 0; k < FRAME_LEN + 3; k++)
      drive(1'b0, 1'b1, (k > 50) ? 300 : 1, (k >= FRAME_LEN - 2) ? "R7" : "R8");

    // R4: restart mid-frame with another code
    drive(1'b1, 1'b0, 37, "R4");
    for (int k = 0; k < 100; k++) drive(1'b0, 1'b1, 37, "R8");
    for (int k = 0; k < 5; k++)   drive(1'b0, 1'b0, 37, "R5");

    @(negedge clk);
    chip_adv = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule